// File: doc/BRIEF.md
# Antiblooming Gate Clock Generator

This block produces the single pulse stream that drives the antiblooming gate of a CCD image sensor. It divides the master clock (nominally 14.318 MHz) down to one of four pulse rates: about 250 kHz, 500 kHz, 1 MHz, or about 2.2 MHz from an alternating 6/7 division. A three-bit mode input picks the rate. It also picks whether the pulses run all the time or only while the horizontal-blanking strobe from the line timer is high.

The mode is captured only when a new line starts, which is the rising edge of the blanking strobe, so a change on the mode pins never cuts a pulse short in the middle of a line. In the modes gated to flyback, the divider restarts at every line start, so the burst has the same phase on every line. An active-low standby input forces the output high and overrides everything else.

Top module: `ccd_abg_clkgen`

## Requirements
- R1: With mode 000 captured and standby inactive, `abg_out` is low in every cycle.
- R2: Modes 001, 010 and 011 clock only during blanking. Their rise-to-rise periods are 56, 14 and alternating 6/7 master-clock cycles.
- R3: In a mode whose top bit is 0, `abg_out` is low from the second clock edge after `hblank` is sampled low until blanking starts again.
- R4: Modes 100, 101, 110 and 111 clock regardless of `hblank`. Their periods are 56, 28, 14 and alternating 6/7 cycles, and the divider is not restarted at line start.
- R5: While `stdby_n` is low, `abg_out` is high from the next clock edge, whatever the mode and blanking state.
- R6: In modes 001 to 011, `abg_out` rises at the second clock edge after the rising edge of `hblank` is sampled, on every line. In the 2.2 MHz rate the high and low phases last 3, 3, 3 and 4 cycles, starting with a high phase.
- R7: `mode_sel` is captured only in the cycle where `hblank` is sampled high after being sampled low. Changes at any other time have no effect until then.
- R8: After reset `abg_out` is low, and the block acts as mode 000 until the first line start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 3 | Mode: bit 2 = 1 continuous, 0 flyback-only; bits 1:0 select the rate |
| hblank | input | 1 | Horizontal-blanking strobe, high during flyback; its rising edge marks line start |
| stdby_n | input | 1 | Standby, active low; forces `abg_out` high |
| abg_out | output | 1 | Antiblooming gate pulse stream |

## Verification
Standby entry and line start can land in the same cycle. That cycle decides both the forced-high output and the mode capture plus divider restart. The bench drives `stdby_n` low on the same edge that `hblank` rises in a flyback-only mode. It expects the output high from the next edge through the whole line, with no low cycle from the restart. It then releases standby at the next line start and checks that the burst follows the mode captured during standby, first rise and pulse count included. Rates are judged by rise-to-rise intervals and rise counts in the blanking window, measured on a line after the mode has settled.

// File: rtl/abg_pkg.sv
// Shared types for the antiblooming clock generator.
// Assumes a 3-bit mode code: bit 2 selects continuous clocking,
// bits 1:0 select the rate, and 000 disables pulsing.
package abg_pkg;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'd0,   // divide by 56
        RATE_MED  = 2'd1,   // divide by 28
        RATE_FAST = 2'd2,   // divide by 14
        RATE_TOP  = 2'd3    // alternate divide by 6 and 7
    } abg_rate_e;

    typedef struct packed {
        logic      enable;
        logic      gated;
        abg_rate_e rate;
    } abg_cfg_t;

    // Turn a captured mode code into enable, gating and rate.
    function automatic abg_cfg_t decode_mode(input logic [2:0] m);
        abg_cfg_t c;
        c.enable = (m != 3'b000);
        c.gated  = ~m[2];
        case (m)
            3'b101:          c.rate = RATE_MED;
            3'b010, 3'b110:  c.rate = RATE_FAST;
            3'b011, 3'b111:  c.rate = RATE_TOP;
            default:         c.rate = RATE_SLOW;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/abg_line_sync.sv
// Line-start detector and mode capture register.
// Assumes hblank is synchronous to clk; a line starts when hblank is
// sampled high after being sampled low. The mode is held between starts.
module abg_line_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hblank,
    input  logic [2:0] mode_sel,
    output logic       hb_q,
    output logic       line_start,
    output logic [2:0] mode_q
);

    assign line_start = hblank & ~hb_q;

    // Remember last cycle's blanking level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hb_q <= 1'b0;
        else        hb_q <= hblank;
    end

    // Capture the mode pins only at the start of a line.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_q <= 3'b000;
        else if (line_start) mode_q <= mode_sel;
    end

endmodule

// File: rtl/abg_rate_div.sv
// Half-period divider producing a square toggle at the selected rate.
// Assumes restart is a single-cycle pulse; after restart the toggle is
// high and the first half period begins. A counter value above the new
// limit (after a rate change) wraps on the next cycle.
module abg_rate_div
    import abg_pkg::*;
#(
    parameter int HALF_SLOW  = 28,
    parameter int HALF_MED   = 14,
    parameter int HALF_FAST  = 7,
    parameter int HALF_TOP_A = 3,
    parameter int HALF_TOP_B = 4,
    parameter bit TOP_DITHER = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  abg_rate_e rate,
    output logic      tog
);

    localparam int CNT_W = $clog2(HALF_SLOW + 1);
    localparam logic [CNT_W-1:0] LIM_SLOW  = CNT_W'(HALF_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_MED   = CNT_W'(HALF_MED - 1);
    localparam logic [CNT_W-1:0] LIM_FAST  = CNT_W'(HALF_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_TOP_A = CNT_W'(HALF_TOP_A - 1);
    localparam logic [CNT_W-1:0] LIM_TOP_B = CNT_W'(HALF_TOP_B - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] lim_top;
    logic [1:0]       hp_idx;

    // The top rate either lengthens every fourth half period or stays flat.
    generate
        if (TOP_DITHER) begin : g_dither
            assign lim_top = (hp_idx == 2'd3) ? LIM_TOP_B : LIM_TOP_A;
        end else begin : g_flat
            assign lim_top = LIM_TOP_A;
        end
    endgenerate

    // Pick the terminal count of the current half period.
    always_comb begin
        case (rate)
            RATE_SLOW: lim = LIM_SLOW;
            RATE_MED:  lim = LIM_MED;
            RATE_FAST: lim = LIM_FAST;
            RATE_TOP:  lim = lim_top;
            default:   lim = LIM_SLOW;
        endcase
    end

    // Count half periods and flip the toggle at each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tog    <= 1'b0;
            hp_idx <= 2'd0;
        end else if (restart) begin
            cnt    <= '0;
            tog    <= 1'b1;
            hp_idx <= 2'd0;
        end else if (cnt >= lim) begin
            cnt    <= '0;
            tog    <= ~tog;
            hp_idx <= hp_idx + 2'd1;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/abg_drive_stage.sv
// Registered output stage: standby override, disable, flyback gating.
// Assumes stdby_n is synchronous; standby has the highest priority and
// drives the gate high, and an idle gate rests low.
module abg_drive_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic stdby_n,
    input  logic enable,
    input  logic gated,
    input  logic hb_q,
    input  logic tog,
    output logic abg_out
);

    // Select the next output level by priority and register it.
    always_ff @(posedge clk) begin
        if (!rst_n)              abg_out <= 1'b0;
        else if (!stdby_n)       abg_out <= 1'b1;
        else if (!enable)        abg_out <= 1'b0;
        else if (gated && !hb_q) abg_out <= 1'b0;
        else                     abg_out <= tog;
    end

endmodule

// File: rtl/ccd_abg_clkgen.sv
// Antiblooming gate clock generator top.
// Captures the mode at each line start and restarts the divider there
// in flyback-only modes. Drives one pulse stream gated by blanking,
// mode and standby. Assumes all inputs are synchronous to clk.
module ccd_abg_clkgen
    import abg_pkg::*;
#(
    parameter int HALF_SLOW  = 28,
    parameter int HALF_MED   = 14,
    parameter int HALF_FAST  = 7,
    parameter int HALF_TOP_A = 3,
    parameter int HALF_TOP_B = 4,
    parameter bit TOP_DITHER = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       hblank,
    input  logic       stdby_n,
    output logic       abg_out
);

    logic       hb_q;
    logic       line_start;
    logic [2:0] mode_q;
    logic       restart;
    logic       tog;
    abg_cfg_t   cfg;

    assign cfg     = decode_mode(mode_q);
    // Flyback-only modes restart the divider at the line they begin on.
    assign restart = line_start & ~mode_sel[2];

    abg_line_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hblank     (hblank),
        .mode_sel   (mode_sel),
        .hb_q       (hb_q),
        .line_start (line_start),
        .mode_q     (mode_q)
    );

    abg_rate_div #(
        .HALF_SLOW  (HALF_SLOW),
        .HALF_MED   (HALF_MED),
        .HALF_FAST  (HALF_FAST),
        .HALF_TOP_A (HALF_TOP_A),
        .HALF_TOP_B (HALF_TOP_B),
        .TOP_DITHER (TOP_DITHER)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .rate    (cfg.rate),
        .tog     (tog)
    );

    abg_drive_stage u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .stdby_n (stdby_n),
        .enable  (cfg.enable),
        .gated   (cfg.gated),
        .hb_q    (hb_q),
        .tog     (tog),
        .abg_out (abg_out)
    );

endmodule

// File: rtl/ccd_abg_clkgen_chk.sv
// Property checker for the antiblooming clock generator, bound to the top.
// Observes ports plus the captured mode and registered blanking level.
module ccd_abg_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       hblank,
    input logic       stdby_n,
    input logic       abg_out,
    input logic [2:0] mode_q,
    input logic       hb_q
);

    // R1: disabled mode keeps the gate low outside standby.
    p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == 3'b000 && $past(stdby_n)) |-> !abg_out);

    // R3: flyback-only modes are silent outside blanking.
    p_gated_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stdby_n) && !$past(mode_q[2]) && !$past(hb_q)) |-> !abg_out);

    // R5: standby forces the gate high on the next edge.
    p_standby_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stdby_n |=> abg_out);

    // R6: a flyback-only line begins with a high phase two edges after start.
    p_restart_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !hb_q && !mode_sel[2] && mode_sel != 3'b000) ##1 stdby_n
        |=> abg_out);

    // R7: the captured mode changes only after a line start.
    p_mode_line_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(hblank) && !$past(hb_q)));

endmodule

bind ccd_abg_clkgen ccd_abg_clkgen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .hblank   (hblank),
    .stdby_n  (stdby_n),
    .abg_out  (abg_out),
    .mode_q   (mode_q),
    .hb_q     (hb_q)
);

// File: tb/ccd_abg_clkgen_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table over all eight modes, then directed tests for reset,
// mid-line mode changes and standby coinciding with line start.
module ccd_abg_clkgen_tb_top;

    localparam int BLANK = 157;
    localparam int LINE  = 910;
    localparam int NV    = 8;

    // Per mode: expected rises in the blanking window (-1: continuous),
    // and the min/max rise-to-rise interval (0/0: no pulses).
    localparam logic [2:0] V_MODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int         V_RISE [NV] = '{0, 3, 12, 25, -1, -1, -1, -1};
    localparam int         V_MIN  [NV] = '{0, 56, 14, 6, 56, 28, 14, 6};
    localparam int         V_MAX  [NV] = '{0, 56, 14, 7, 56, 28, 14, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       hblank = 1'b0;
    logic       stdby_n = 1'b1;
    logic       abg_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int st_rwin, st_hout, st_low, st_first, st_min, st_max;
    logic prev_s = 1'b0;

    always #2 clk = ~clk;

    ccd_abg_clkgen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .hblank   (hblank),
        .stdby_n  (stdby_n),
        .abg_out  (abg_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One line: blanking for blen cycles, then active. Standby level sb0
    // is applied with the blanking rise; mode may change at cycle chg_at.
    task automatic run_line(input int blen, input int chg_at,
                            input logic [2:0] chg_mode, input logic sb0);
        int last_rise = -1;
        logic v;
        st_rwin = 0; st_hout = 0; st_low = 0; st_first = -1;
        st_min = 0; st_max = 0;
        for (int c = 0; c < LINE; c++) begin
            @(negedge clk);
            v = abg_out;
            if (c >= 1 && !v) st_low++;
            if (v && !prev_s) begin
                if (c >= 2 && c <= blen + 1) st_rwin++;
                if (st_first < 0) st_first = c;
                if (last_rise >= 0) begin
                    if (st_min == 0 || c - last_rise < st_min) st_min = c - last_rise;
                    if (c - last_rise > st_max) st_max = c - last_rise;
                end
                last_rise = c;
            end
            if (v && c >= blen + 2) st_hout++;
            prev_s = v;
            if (c == 0) stdby_n = sb0;
            if (c == chg_at) mode_sel = chg_mode;
            hblank = (c < blen);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int highs;
        mode_sel = 3'd7;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R8: low after reset and silent until the first line start.
        @(negedge clk);
        chk("R8 reset level", abg_out, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (abg_out) highs++;
        end
        chk("R8 idle before first line", highs, 0);

        // Table walk: settle one line, measure the next.
        for (int k = 0; k < NV; k++) begin
            mode_sel = V_MODE[k];
            run_line(BLANK, -1, 3'd0, 1'b1);
            run_line(BLANK, -1, 3'd0, 1'b1);
            if (V_RISE[k] >= 0) begin
                chk(k == 0 ? "R1 no pulses" : "R2 rises in blanking", st_rwin, V_RISE[k]);
                chk("R3 low outside blanking", st_hout, 0);
                if (k != 0) chk("R6 first rise cycle", st_first, 2);
            end else begin
                chk("R4 pulses outside blanking", int'(st_hout > 0), 1);
            end
            if (V_MAX[k] != 0) begin
                chk(V_RISE[k] >= 0 ? "R2 min period" : "R4 min period", st_min, V_MIN[k]);
                chk(V_RISE[k] >= 0 ? "R2 max period" : "R4 max period", st_max, V_MAX[k]);
            end
        end

        // R6: phase repeats on consecutive lines in the 2.2 MHz gated mode.
        mode_sel = 3'd3;
        run_line(BLANK, -1, 3'd0, 1'b1);
        run_line(BLANK, -1, 3'd0, 1'b1);
        chk("R6 phase line A", st_first, 2);
        run_line(BLANK, -1, 3'd0, 1'b1);
        chk("R6 phase line B", st_first, 2);
        chk("R6 rise count line B", st_rwin, 25);

        // R7: mid-line change to mode 7 is ignored until the next line.
        mode_sel = 3'd4;
        run_line(BLANK, -1, 3'd0, 1'b1);
        run_line(BLANK, 400, 3'd7, 1'b1);
        chk("R7 min period after mid-line change", st_min, 56);
        chk("R7 max period after mid-line change", st_max, 56);
        run_line(BLANK, -1, 3'd0, 1'b1);
        run_line(BLANK, -1, 3'd0, 1'b1);
        chk("R7 new mode min period", st_min, 6);
        chk("R7 new mode max period", st_max, 7);

        // R5: standby entered on the same cycle as a gated line start.
        mode_sel = 3'd2;
        run_line(BLANK, -1, 3'd0, 1'b1);
        run_line(BLANK, -1, 3'd0, 1'b0);
        chk("R5 high through standby line", st_low, 0);
        run_line(BLANK, -1, 3'd0, 1'b1);
        chk("R5 gated burst after release", st_rwin, 12);
        chk("R5 first rise after release", st_first, 2);
        chk("R3 low after release outside blanking", st_hout, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule